// File: doc/BRIEF.md
# Paged Register Aperture Decoder

This block fronts a large bank of configuration registers with a small 4 KB direct register space on a 32-bit access bus. Most of the bank cannot be addressed directly. A shared control register carries a 6-bit page number. Any access that lands in the top 1 KB of the direct space (byte offsets 0xC00 to 0xFFF) is steered to the chosen 1 KB page. Within that page, the low offset bits pick the word.

Software reaches a paged register in two steps. It first reads the control register, replaces only the page field and writes the result back. It then accesses 0xC00 plus the low 10 bits of the register's full offset. The same control register also holds two independent programmed-I/O enable bits, which the block drives out as levels. A set of unpaged registers at the bottom of the direct space is reached without paging. Each accepted request gets exactly one response on the following cycle.

Top module: `paged_csr_window`

## Requirements
- R1: After reset, `reqReady` is 1, `rspValid` is 0, `pageSel`, `axiPioEn` and `pexPioEn` are 0, and a read of the control register returns 0.
- R2: A request is accepted when `reqValid` and `reqReady` are both 1 at a clock edge. Its response (`rspValid`=1) appears in the next cycle. `reqReady` is 0 during that response cycle, and a request presented while `reqReady` is 0 has no effect and produces no response.
- R3: The control register at byte offset 0x808 stores all 32 written bits and reads them back. Bits [18:13] drive `pageSel`, bit 0 drives `axiPioEn` and bit 1 drives `pexPioEn`.
- R4: A byte offset in 0xC00..0xFFF addresses the paged word {pageSel, offset[9:2]}. Writing one page leaves the same offset of every other page unchanged, and a read returns the stored word.
- R5: A new page value written to the control register is used by the very next accepted aperture access.
- R6: Byte offsets below 4*UNPAGED_WORDS (0x000..0x03F by default) address unpaged storage words that do not depend on `pageSel`.
- R7: A successful write responds with `rspData`=0 and `rspErr`=0. A successful read responds with `rspErr`=0.
- R8: An access to any other direct offset, or to the aperture while `pageSel` >= NUM_PAGES, responds with `rspErr`=1 and `rspData`=0, and a write in that case changes no register.
- R9: Address bits [1:0] are ignored, so byte offsets 0x006 and 0x004 reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 12 | Direct byte offset |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Response for the request accepted last cycle |
| rspData | output | 32 | Read data (0 for writes and errors) |
| rspErr | output | 1 | Access hit no modelled register |
| axiPioEn | output | 1 | Control bit 0: first programmed-I/O path enable |
| pexPioEn | output | 1 | Control bit 1: second programmed-I/O path enable |
| pageSel | output | 6 | Current page field of the control register |

## Verification
A page field that is latched late or not at all shows up on the next aperture read. That read returns the data of the previous page, and the bench reaches it by writing distinct values at the same offset in two pages. A wrong paged index, such as a dropped low offset bit, makes two aperture words alias. A write accepted while a response is pending shows up one cycle later as a second `rspValid`. An address wrongly treated as mapped shows up at once as `rspErr` being low. The bench also reads the neighbouring page back, which shows any write that was wrongly applied.

// File: rtl/pcsr_pkg.sv
package pcsr_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CTRL = 2'd1,
    TGT_UNP  = 2'd2,
    TGT_PAGE = 2'd3
  } tgt_e;

  // strobes from the decoder to the storage datapath
  typedef struct packed {
    logic load;   // request accepted this cycle
    logic write;  // accepted request is a write
    tgt_e tgt;    // which storage the access lands in
  } strobe_t;
endpackage

// File: rtl/pcsr_ctrl.sv
module pcsr_ctrl
  import pcsr_pkg::*;
#(
  parameter int PAGE_BITS     = 6,
  parameter int NUM_PAGES     = 4,
  parameter int PAGE_BYTES    = 1024,
  parameter int UNPAGED_WORDS = 16,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET   = 12'h808,
  parameter logic [ADDR_W-1:0] APERTURE_BASE = 12'hC00,
  localparam int WIN_IDX_W = $clog2(PAGE_BYTES / 4),
  localparam int PG_IDX_W  = $clog2(NUM_PAGES),
  localparam int PIDX_W    = PG_IDX_W + WIN_IDX_W,
  localparam int UIDX_W    = $clog2(UNPAGED_WORDS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [PAGE_BITS-1:0] curPage,
  output logic                 reqReady,
  output logic                 rspValid,
  output strobe_t              stb,
  output logic [UIDX_W-1:0]    unpIdx,
  output logic [PIDX_W-1:0]    pagedIdx
);
  logic accept;
  logic isCtrl;
  logic isUnp;
  logic isAperture;
  logic pageOk;

  assign reqReady = !rspValid;
  assign accept   = reqValid && reqReady;

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= accept;
  end

  always_comb begin
    isCtrl     = ({reqAddr[ADDR_W-1:2], 2'b00} == CTRL_OFFSET);
    isUnp      = (reqAddr < ADDR_W'(UNPAGED_WORDS * 4));
    isAperture = (reqAddr >= APERTURE_BASE);
    pageOk     = (32'(curPage) < NUM_PAGES);
    unpIdx     = reqAddr[UIDX_W+1:2];
    pagedIdx   = {curPage[PG_IDX_W-1:0], reqAddr[WIN_IDX_W+1:2]};

    stb.load  = accept;
    stb.write = accept && reqWrite;
    if (isCtrl)                    stb.tgt = TGT_CTRL;
    else if (isUnp)                stb.tgt = TGT_UNP;
    else if (isAperture && pageOk) stb.tgt = TGT_PAGE;
    else                           stb.tgt = TGT_NONE;
  end
endmodule

// File: rtl/pcsr_dpath.sv
module pcsr_dpath
  import pcsr_pkg::*;
#(
  parameter int PAGE_BITS     = 6,
  parameter int PAGE_LSB      = 13,
  parameter int NUM_PAGES     = 4,
  parameter int PAGE_BYTES    = 1024,
  parameter int UNPAGED_WORDS = 16,
  localparam int WIN_WORDS = PAGE_BYTES / 4,
  localparam int MEM_WORDS = NUM_PAGES * WIN_WORDS,
  localparam int PIDX_W    = $clog2(MEM_WORDS),
  localparam int UIDX_W    = $clog2(UNPAGED_WORDS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [UIDX_W-1:0]    unpIdx,
  input  logic [PIDX_W-1:0]    pagedIdx,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rspData,
  output logic                 rspErr,
  output logic [PAGE_BITS-1:0] curPage,
  output logic                 axiPioEn,
  output logic                 pexPioEn
);
  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] unpRegs [UNPAGED_WORDS];
  logic [DATA_W-1:0] pagedMem [MEM_WORDS];
  logic [DATA_W-1:0] readMux;

  assign curPage  = ctrlReg[PAGE_LSB +: PAGE_BITS];
  assign axiPioEn = ctrlReg[0];
  assign pexPioEn = ctrlReg[1];

  always_ff @(posedge clk) begin
    if (!rstN) ctrlReg <= '0;
    else if (stb.write && stb.tgt == TGT_CTRL) ctrlReg <= wdata;
  end

  for (genvar i = 0; i < UNPAGED_WORDS; i++) begin : g_unp
    always_ff @(posedge clk) begin
      if (!rstN) unpRegs[i] <= '0;
      else if (stb.write && stb.tgt == TGT_UNP && unpIdx == UIDX_W'(i))
        unpRegs[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.write && stb.tgt == TGT_PAGE) pagedMem[pagedIdx] <= wdata;
  end

  always_comb begin
    unique case (stb.tgt)
      TGT_CTRL: readMux = ctrlReg;
      TGT_UNP:  readMux = unpRegs[unpIdx];
      TGT_PAGE: readMux = pagedMem[pagedIdx];
      default:  readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspData <= '0;
      rspErr  <= 1'b0;
    end else if (stb.load) begin
      rspErr  <= (stb.tgt == TGT_NONE);
      rspData <= stb.write ? '0 : readMux;
    end
  end
endmodule

// File: rtl/paged_csr_window.sv
module paged_csr_window
  import pcsr_pkg::*;
#(
  parameter int PAGE_BITS     = 6,
  parameter int PAGE_LSB      = 13,
  parameter int NUM_PAGES     = 4,
  parameter int PAGE_BYTES    = 1024,
  parameter int UNPAGED_WORDS = 16,
  parameter logic [11:0] CTRL_OFFSET   = 12'h808,
  parameter logic [11:0] APERTURE_BASE = 12'hC00,
  localparam int PIDX_W = $clog2(NUM_PAGES) + $clog2(PAGE_BYTES / 4),
  localparam int UIDX_W = $clog2(UNPAGED_WORDS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic                 reqWrite,
  input  logic [11:0]          reqAddr,
  input  logic [31:0]          reqWdata,
  output logic                 rspValid,
  output logic [31:0]          rspData,
  output logic                 rspErr,
  output logic                 axiPioEn,
  output logic                 pexPioEn,
  output logic [PAGE_BITS-1:0] pageSel
);
  strobe_t            stb;
  logic [UIDX_W-1:0]  unpIdx;
  logic [PIDX_W-1:0]  pagedIdx;

  pcsr_ctrl #(
    .PAGE_BITS(PAGE_BITS), .NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES),
    .UNPAGED_WORDS(UNPAGED_WORDS), .CTRL_OFFSET(CTRL_OFFSET),
    .APERTURE_BASE(APERTURE_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .curPage(pageSel), .reqReady(reqReady),
    .rspValid(rspValid), .stb(stb), .unpIdx(unpIdx), .pagedIdx(pagedIdx)
  );

  pcsr_dpath #(
    .PAGE_BITS(PAGE_BITS), .PAGE_LSB(PAGE_LSB), .NUM_PAGES(NUM_PAGES),
    .PAGE_BYTES(PAGE_BYTES), .UNPAGED_WORDS(UNPAGED_WORDS)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .unpIdx(unpIdx), .pagedIdx(pagedIdx),
    .wdata(reqWdata), .rspData(rspData), .rspErr(rspErr), .curPage(pageSel),
    .axiPioEn(axiPioEn), .pexPioEn(pexPioEn)
  );
endmodule

// File: rtl/pcsr_checker.sv
module pcsr_checker #(
  parameter int PAGE_BITS = 6,
  parameter int PAGE_LSB  = 13,
  parameter logic [11:0] CTRL_OFFSET = 12'h808
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic                 reqWrite,
  input logic [11:0]          reqAddr,
  input logic [31:0]          reqWdata,
  input logic                 rspValid,
  input logic [31:0]          rspData,
  input logic                 rspErr,
  input logic                 axiPioEn,
  input logic                 pexPioEn,
  input logic [PAGE_BITS-1:0] pageSel
);
  logic acc;
  logic ctrlWr;
  assign acc    = reqValid && reqReady;
  assign ctrlWr = acc && reqWrite && ({reqAddr[11:2], 2'b00} == CTRL_OFFSET);

  p_rsp_follows_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    acc |=> rspValid);
  p_rsp_needs_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(acc));
  p_busy_in_rsp_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);
  p_page_from_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> pageSel == $past(reqWdata[PAGE_LSB +: PAGE_BITS]));
  p_enables_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWr |=> $stable(axiPioEn) && $stable(pexPioEn) && $stable(pageSel));
  p_err_zero_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> rspData == 32'h0);
endmodule

bind paged_csr_window pcsr_checker #(
  .PAGE_BITS(PAGE_BITS), .PAGE_LSB(PAGE_LSB), .CTRL_OFFSET(CTRL_OFFSET)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
  .rspValid(rspValid), .rspData(rspData), .rspErr(rspErr),
  .axiPioEn(axiPioEn), .pexPioEn(pexPioEn), .pageSel(pageSel)
);

// File: tb/paged_csr_window_tb.sv
`timescale 1ns/1ps
module paged_csr_window_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady, rspValid, rspErr, axiPioEn, pexPioEn;
  logic [31:0] rspData;
  logic [5:0]  pageSel;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  paged_csr_window u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .rspErr(rspErr),
    .axiPioEn(axiPioEn), .pexPioEn(pexPioEn), .pageSel(pageSel)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access; data and error are taken in the response cycle
  task automatic access(input bit wr, input logic [11:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output logic er);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wd;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (!rspValid || reqReady) begin
      check(1'b0, "R2 response cycle", {30'b0, rspValid, reqReady}, 32'h2);
    end
    rd = rspData; er = rspErr;
  endtask

  task automatic rd32(input logic [11:0] a, output logic [31:0] d, output logic e);
    access(1'b0, a, 32'h0, d, e);
  endtask

  task automatic wr32(input logic [11:0] a, input logic [31:0] v, input string req);
    logic [31:0] d; logic e;
    access(1'b1, a, v, d, e);
    check(d == 0 && e == expErr(a), {req, " write response"}, {d[30:0], e}, {31'b0, expErr(a)});
  endtask

  logic [5:0] modelPage = '0;
  function automatic logic expErr(input logic [11:0] a);
    if ({a[11:2], 2'b00} == 12'h808) return 1'b0;
    if (a < 12'h040) return 1'b0;
    if (a >= 12'hC00 && modelPage < 6'd4) return 1'b0;
    return 1'b1;
  endfunction

  // read-modify-write of the page field only
  task automatic setPage(input logic [5:0] p);
    logic [31:0] c; logic e;
    rd32(12'h808, c, e);
    c = (c & ~(32'h3F << 13)) | (32'(p) << 13);
    wr32(12'h808, c, "R3");
    modelPage = p;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    check(reqReady == 1 && rspValid == 0, "R1 handshake idle", {30'b0, reqReady, rspValid}, 32'h2);
    check(pageSel == 0 && !axiPioEn && !pexPioEn, "R1 outputs zero", {24'b0, pageSel, axiPioEn, pexPioEn}, 32'h0);
    rd32(12'h808, d, e);
    check(d == 0 && !e, "R1 control reads zero", d, 32'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d; logic e;
    logic [31:0] v = 32'h5A04_6001;
    wr32(12'h808, v, "R3");
    check(pageSel == v[18:13], "R3 page field", {26'b0, pageSel}, {26'b0, v[18:13]});
    check(axiPioEn == 1 && pexPioEn == 0, "R3 enables", {30'b0, axiPioEn, pexPioEn}, 32'h2);
    rd32(12'h80A, d, e);
    check(d == v && !e, "R3 readback", d, v);
    wr32(12'h808, 32'h0000_0003, "R3");
    check(axiPioEn && pexPioEn && pageSel == 0, "R3 both enables", {24'b0, pageSel, axiPioEn, pexPioEn}, 32'h3);
    modelPage = 0;
  endtask

  task automatic t_paged();
    logic [31:0] d; logic e;
    setPage(6'd0); wr32(12'hC10, 32'hAAAA_0000, "R4");
    setPage(6'd1); wr32(12'hC10, 32'hBBBB_1111, "R4");
    check(axiPioEn && pexPioEn, "R3 enables kept across page change", {30'b0, axiPioEn, pexPioEn}, 32'h3);
    setPage(6'd0); rd32(12'hC10, d, e);
    check(d == 32'hAAAA_0000 && !e, "R5 page 0 read right after switch", d, 32'hAAAA_0000);
    setPage(6'd1); rd32(12'hC10, d, e);
    check(d == 32'hBBBB_1111 && !e, "R4 page 1 kept its word", d, 32'hBBBB_1111);
    wr32(12'hC14, 32'h1234_5678, "R4");
    rd32(12'hC10, d, e);
    check(d == 32'hBBBB_1111, "R4 neighbouring offset untouched", d, 32'hBBBB_1111);
    setPage(6'd3); wr32(12'hFFC, 32'hCAFE_F00D, "R4");
    wr32(12'hC00, 32'h0000_0C00, "R4");
    rd32(12'hFFC, d, e);
    check(d == 32'hCAFE_F00D && !e, "R4 last word of last page", d, 32'hCAFE_F00D);
    rd32(12'hC00, d, e);
    check(d == 32'h0000_0C00, "R4 first word of page", d, 32'h0000_0C00);
  endtask

  task automatic t_unpaged();
    logic [31:0] d; logic e;
    setPage(6'd0);
    wr32(12'h004, 32'h0D0D_0404, "R6");
    wr32(12'h03C, 32'h3C3C_3C3C, "R6");
    setPage(6'd2);
    rd32(12'h004, d, e);
    check(d == 32'h0D0D_0404 && !e, "R6 unpaged independent of page", d, 32'h0D0D_0404);
    rd32(12'h03C, d, e);
    check(d == 32'h3C3C_3C3C && !e, "R6 last unpaged word", d, 32'h3C3C_3C3C);
    rd32(12'h006, d, e);
    check(d == 32'h0D0D_0404 && !e, "R9 low address bits ignored", d, 32'h0D0D_0404);
    wr32(12'h009, 32'h9999_0008, "R9");
    rd32(12'h008, d, e);
    check(d == 32'h9999_0008, "R9 write through unaligned offset", d, 32'h9999_0008);
  endtask

  task automatic t_errors();
    logic [31:0] d; logic e;
    rd32(12'h040, d, e);
    check(e && d == 0, "R8 first unmapped offset", {d[30:0], e}, 32'h1);
    rd32(12'hBFC, d, e);
    check(e && d == 0, "R8 just below aperture", {d[30:0], e}, 32'h1);
    wr32(12'h500, 32'hDEAD_BEEF, "R8");
    setPage(6'd5);
    wr32(12'hC10, 32'hDEAD_DEAD, "R8");
    rd32(12'hC10, d, e);
    check(e && d == 0, "R8 unmodelled page read", {d[30:0], e}, 32'h1);
    setPage(6'd1);
    rd32(12'hC10, d, e);
    check(d == 32'hBBBB_1111 && !e, "R8 write to unmodelled page ignored", d, 32'hBBBB_1111);
  endtask

  task automatic t_busy();
    logic [31:0] d; logic e;
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = 12'h010; reqWdata = 32'h1111_1111;
    @(negedge clk);
    check(rspValid && !reqReady, "R2 busy during response", {30'b0, rspValid, reqReady}, 32'h2);
    reqWdata = 32'h2222_2222;
    @(negedge clk);
    check(!rspValid, "R2 no response for refused request", {31'b0, rspValid}, 32'h0);
    reqValid = 0;
    rd32(12'h010, d, e);
    check(d == 32'h1111_1111, "R2 refused write had no effect", d, 32'h1111_1111);
  endtask

  task automatic t_read_ok();
    logic [31:0] d; logic e;
    rd32(12'h808, d, e);
    check(!e, "R7 read of mapped register has no error", {31'b0, e}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_paged();
    t_unpaged();
    t_errors();
    t_busy();
    t_read_ok();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule